// File: doc/BRIEF.md
# SPI Master Frame Sequencer

This block is the master end of a synchronous serial link. It moves one data word per frame in both directions at once. A parallel client raises `start` while `ready` is high. The block then latches the transmit word and the clocking options, pulls `frm_n` low and produces `2*DATA_W` serial clock transitions. It shifts the transmit word out on `sdo` and collects `sdi` into a receive word. Once the frame is over, `frm_n` returns high and `done` pulses once.

The serial clock comes from a half-period counter. It runs on the system clock and is reloaded from `half_div`. The idle clock level comes from the polarity option. The phase option sets how long the clock stays idle before the first transition and after the last one. With phase 0 that is one full serial period in front and half a period behind. With phase 1 it is half a period in front and one full period behind. Every frame therefore lasts `2*DATA_W+2` half-periods.

Only format code `00` is implemented. For any other code the polarity and phase inputs are ignored, and the block runs as if both were 0.

Top module: `spi_frame_master`

## Requirements
- R1: Outside a frame, `frm_n` is high, `ready` is high, and `sclk` equals the effective polarity: `pol` when `fmt` is 2'b00, and 0 otherwise.
- R2: When `fmt` is not 2'b00, `pol` and `pha` have no effect. The frame is produced exactly as it would be with polarity 0 and phase 0.
- R3: With effective phase 0, the first `sclk` transition comes 2*H system cycles after `frm_n` falls, and `frm_n` rises H cycles after the last transition. H is the half-period in cycles.
- R4: With effective phase 1, the first `sclk` transition comes H cycles after `frm_n` falls, and `frm_n` rises 2*H cycles after the last transition.
- R5: Each frame holds `frm_n` low for exactly (2*DATA_W+2)*H cycles and contains exactly 2*DATA_W `sclk` transitions. `sclk` is back at its idle level before `frm_n` rises.
- R6: When polarity equals phase, `sdo` changes within a frame only together with a falling `sclk` transition, and `sdi` is sampled on rising transitions.
- R7: When polarity differs from phase, `sdo` changes within a frame only together with a rising `sclk` transition, and `sdi` is sampled on falling transitions.
- R8: Data moves MSB first. The MSB of the transmit word is on `sdo` from the cycle in which `frm_n` falls. Bit k of `rx_word` is the `sdi` value sampled on the (DATA_W-k)-th sampling transition.
- R9: `start` is accepted only while `ready` is high. `ready` is low for the whole frame. A `start` held during a frame, together with changes to `tx_word`, starts no extra frame and does not alter the word being sent.
- R10: `done` is high for exactly one cycle, namely the first cycle with `frm_n` high again. `rx_word` holds the received word from that cycle on.
- R11: H is `half_div`, with a value of 0 taken as 1. Polarity, phase and `half_div` are captured when `start` is accepted, so changing them during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a frame |
| tx_word | input | DATA_W | Word to transmit |
| fmt | input | 2 | Frame format code; only 2'b00 enables the polarity and phase options |
| pol | input | 1 | Clock polarity (idle level) |
| pha | input | 1 | Clock phase (lead/tail timing and sampling edge) |
| half_div | input | DIV_W | Serial clock half-period in system cycles |
| sdi | input | 1 | Serial data from the slave |
| ready | output | 1 | High when a start will be accepted |
| done | output | 1 | One-cycle pulse at frame end |
| rx_word | output | DATA_W | Last received word |
| frm_n | output | 1 | Active-low frame select |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data to the slave |

## Verification
The bench sweeps all four polarity/phase pairs over several divisor values, zero included. In each frame it measures the lead and tail gaps, the frame length and the number of clock transitions. A design that swapped the lead and tail asymmetry, or that treated a divisor of 0 literally, would miss these cycle counts by whole half-periods. The bench also checks that `sdo` moves only on the launch transition and that both words come out MSB first, which catches a sequencer that samples and launches on the wrong edges. It drives non-zero format codes with both options set to 1, holds `start` through a busy frame and changes the options in mid-frame. This exposes a design that honoured ignored inputs, accepted a second start, or re-read its configuration during a frame.

// File: rtl/spi_fs_pkg.sv
package spi_fs_pkg;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_XFER = 1'b1
   } fs_state_t;

   typedef struct packed {
      logic pol;
      logic pha;
   } fs_mode_t;

   localparam logic [1:0] FMT_SPI = 2'b00;

endpackage

// File: rtl/spi_fs_tick.sv
module spi_fs_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;
   logic             wrap;

   assign wrap = (cnt_q == half - DIV_W'(1));
   assign tick = run && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || wrap) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end
endmodule

// File: rtl/spi_fs_seq.sv
module spi_fs_seq #(
   parameter int DATA_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic tick,
   input  logic pha,
   output logic toggle,
   output logic sample,
   output logic shift,
   output logic finish
);
   localparam int EDGES = 2 * DATA_W;
   localparam int SLOTS = EDGES + 2;
   localparam int CNT_W = $clog2(SLOTS + 1);

   logic [CNT_W-1:0] slot_q;
   logic [CNT_W-1:0] nxt;
   logic [CNT_W-1:0] edge_idx;
   logic             in_win;

   // boundary index about to be reached and the clock edge number it carries
   assign nxt      = slot_q + CNT_W'(1);
   assign edge_idx = nxt - CNT_W'(!pha);
   assign in_win   = (edge_idx != '0) && (edge_idx <= CNT_W'(EDGES));

   assign toggle = tick && in_win;
   // phase 0 samples on odd edges, phase 1 on even edges
   assign sample = toggle && (edge_idx[0] ^ pha);
   // launch edges move the next bit only once a sample has been taken
   assign shift  = toggle && !(edge_idx[0] ^ pha) && (edge_idx > CNT_W'(1));
   assign finish = tick && (nxt == CNT_W'(SLOTS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
      end else if (load) begin
         slot_q <= '0;
      end else if (tick) begin
         slot_q <= nxt;
      end
   end
endmodule

// File: rtl/spi_fs_shift.sv
module spi_fs_shift #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] word_in,
   input  logic              shift,
   input  logic              sample,
   input  logic              sdi,
   output logic              sdo,
   output logic [DATA_W-1:0] rx_bits
);
   logic [DATA_W-1:0] tx_q;
   logic [DATA_W-1:0] rx_q;

   assign sdo     = tx_q[DATA_W-1];
   assign rx_bits = rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q <= '0;
      end else if (load) begin
         tx_q <= word_in;
      end else if (shift) begin
         tx_q <= {tx_q[DATA_W-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q <= '0;
      end else if (sample) begin
         rx_q <= {rx_q[DATA_W-2:0], sdi};
      end
   end
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master #(
   parameter int DATA_W = 8,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] tx_word,
   input  logic [1:0]        fmt,
   input  logic              pol,
   input  logic              pha,
   input  logic [DIV_W-1:0]  half_div,
   input  logic              sdi,
   output logic              ready,
   output logic              done,
   output logic [DATA_W-1:0] rx_word,
   output logic              frm_n,
   output logic              sclk,
   output logic              sdo
);
   import spi_fs_pkg::*;

   generate
      if (DATA_W < 2) begin : g_chk_width
         $error("spi_frame_master: DATA_W must be at least 2");
      end
      if (DIV_W < 1) begin : g_chk_div
         $error("spi_frame_master: DIV_W must be at least 1");
      end
   endgenerate

   fs_state_t         state_q;
   fs_mode_t          mode_live;
   fs_mode_t          mode_q;
   logic [DIV_W-1:0]  half_live;
   logic [DIV_W-1:0]  half_q;
   logic              pol_q;
   logic              pha_q;
   logic              accept;
   logic              running;
   logic              tick;
   logic              toggle;
   logic              sample;
   logic              shift;
   logic              finish;
   logic              sclk_q;
   logic              frm_q;
   logic              done_q;
   logic [DATA_W-1:0] rx_q;
   logic [DATA_W-1:0] rx_bits;

   // options apply only in the SPI format; otherwise mode 0
   assign mode_live.pol = (fmt == FMT_SPI) ? pol : 1'b0;
   assign mode_live.pha = (fmt == FMT_SPI) ? pha : 1'b0;
   assign half_live     = (half_div == '0) ? DIV_W'(1) : half_div;

   assign running = (state_q == ST_XFER);
   assign accept  = start && !running;
   assign pol_q   = mode_q.pol;
   assign pha_q   = mode_q.pha;

   spi_fs_tick #(.DIV_W(DIV_W)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (running),
      .half  (half_q),
      .tick  (tick)
   );

   spi_fs_seq #(.DATA_W(DATA_W)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (accept),
      .tick   (tick),
      .pha    (mode_q.pha),
      .toggle (toggle),
      .sample (sample),
      .shift  (shift),
      .finish (finish)
   );

   spi_fs_shift #(.DATA_W(DATA_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .word_in (tx_word),
      .shift   (shift),
      .sample  (sample),
      .sdi     (sdi),
      .sdo     (sdo),
      .rx_bits (rx_bits)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mode_q  <= '0;
         half_q  <= DIV_W'(1);
         sclk_q  <= 1'b0;
         frm_q   <= 1'b1;
         done_q  <= 1'b0;
         rx_q    <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            state_q <= ST_XFER;
            mode_q  <= mode_live;
            half_q  <= half_live;
            sclk_q  <= mode_live.pol;
            frm_q   <= 1'b0;
         end else if (running) begin
            if (toggle) begin
               sclk_q <= ~sclk_q;
            end
            if (finish) begin
               state_q <= ST_IDLE;
               frm_q   <= 1'b1;
               done_q  <= 1'b1;
               rx_q    <= rx_bits;
            end
         end
      end
   end

   assign ready   = !running;
   assign done    = done_q;
   assign rx_word = rx_q;
   assign frm_n   = frm_q;
   assign sclk    = running ? sclk_q : mode_live.pol;
endmodule

// File: rtl/spi_fs_chk.sv
module spi_fs_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ready,
   input logic       done,
   input logic       frm_n,
   input logic       sclk,
   input logic       sdo,
   input logic       pol,
   input logic [1:0] fmt,
   input logic       pol_q,
   input logic       pha_q
);
   a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> frm_n);

   a_r1_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      frm_n |-> (sclk == ((fmt == 2'b00) ? pol : 1'b0)));

   a_r9_busy_selected: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> !frm_n);

   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (frm_n && !$past(frm_n)));

   a_r5_closes_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frm_n) |-> ($past(sclk) == $past(pol_q)));

   // R6 / R7: data moves only with the launch transition
   a_r6_r7_launch_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (!frm_n && !$past(frm_n) && !$stable(sdo)) |->
         (!$stable(sclk) && (sclk == (pol_q ^ pha_q))));
endmodule

bind spi_frame_master spi_fs_chk u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .ready (ready),
   .done  (done),
   .frm_n (frm_n),
   .sclk  (sclk),
   .sdo   (sdo),
   .pol   (pol),
   .fmt   (fmt),
   .pol_q (pol_q),
   .pha_q (pha_q)
);

// File: tb/spi_frame_master_test.sv
module spi_frame_master_test;
   localparam int CLK_PER = 10;
   localparam int N       = 8;
   localparam int DW      = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [N-1:0]  tx_word = '0;
   logic [1:0]    fmt = 2'b00;
   logic          pol = 1'b0;
   logic          pha = 1'b0;
   logic [DW-1:0] half_div = DW'(1);
   logic          sdi;
   logic          ready, done, frm_n, sclk, sdo;
   logic [N-1:0]  rx_word;

   int checks = 0;
   int errors = 0;

   // expectations for the current frame
   logic         exp_pol = 1'b0, exp_pha = 1'b0;
   int           exp_h = 1;
   logic [N-1:0] exp_tx = '0, exp_rx = '0;

   // monitor state
   int           cyc = 0, t_fall = 0, t_first = 0, t_last = 0;
   int           n_edges = 0, n_samp = 0, sdo_bad = 0, slv = 0;
   int           idle_bad = 0, done_bad = 0, nfr = 0;
   logic [N-1:0] got = '0;
   logic         prev_frm = 1'b1, prev_sclk = 1'b0, prev_sdo = 1'b0;

   spi_frame_master #(.DATA_W(N), .DIV_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
      .fmt(fmt), .pol(pol), .pha(pha), .half_div(half_div), .sdi(sdi),
      .ready(ready), .done(done), .rx_word(rx_word), .frm_n(frm_n),
      .sclk(sclk), .sdo(sdo)
   );

   always #(CLK_PER/2) clk = ~clk;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // slave model and frame measurement, sampled a quarter period after the edge
   always begin
      @(posedge clk);
      #(CLK_PER/4);
      if (!rst_n) begin
         sdi = 1'b0;
      end else begin
         logic samp_lvl;
         logic edge_now;
         cyc++;
         samp_lvl = ~(exp_pol ^ exp_pha);
         edge_now = (sclk != prev_sclk);
         if (prev_frm && !frm_n) begin
            t_fall = cyc; n_edges = 0; n_samp = 0; got = '0; sdo_bad = 0;
            slv = N - 1; sdi = exp_rx[N-1];
         end else if (!prev_frm && !frm_n) begin
            if (sdo != prev_sdo && !(edge_now && sclk != samp_lvl)) sdo_bad++;
            if (edge_now) begin
               n_edges++;
               if (n_edges == 1) t_first = cyc;
               t_last = cyc;
               if (sclk == samp_lvl) begin
                  got = {got[N-2:0], sdo};
                  n_samp++;
               end else if (n_samp > 0 && slv > 0) begin
                  slv--;
                  sdi = exp_rx[slv];
               end
            end
         end else if (!prev_frm && frm_n) begin
            chk(n_edges == 2*N, "R5 transition count", n_edges, 2*N);
            chk(cyc - t_fall == (2*N+2)*exp_h, "R5 frame length", cyc - t_fall, (2*N+2)*exp_h);
            if (exp_pha) begin
               chk(t_first - t_fall == exp_h, "R4 lead time", t_first - t_fall, exp_h);
               chk(cyc - t_last == 2*exp_h, "R4 tail time", cyc - t_last, 2*exp_h);
            end else begin
               chk(t_first - t_fall == 2*exp_h, "R3 lead time", t_first - t_fall, 2*exp_h);
               chk(cyc - t_last == exp_h, "R3 tail time", cyc - t_last, exp_h);
            end
            if (samp_lvl) chk(sdo_bad == 0, "R6 launch on falling", sdo_bad, 0);
            else          chk(sdo_bad == 0, "R7 launch on rising", sdo_bad, 0);
            chk(got == exp_tx, "R8 transmit word", got, exp_tx);
            chk(rx_word == exp_rx, "R8 receive word", rx_word, exp_rx);
            chk(done == 1'b1, "R10 done at release", done, 1);
            nfr++;
         end
         if (frm_n && prev_frm && sclk != ((fmt == 2'b00) ? pol : 1'b0)) idle_bad++;
         if (done && !(!prev_frm && frm_n)) done_bad++;
         prev_frm  = frm_n;
         prev_sclk = sclk;
         prev_sdo  = sdo;
      end
   end

   // kind: 0 plain, 1 start held through the frame, 2 options changed mid-frame
   task automatic run_frame(input logic [1:0] f, input logic p, input logic h, input int d,
                            input logic [N-1:0] tx, input logic [N-1:0] sw, input int kind);
      int n0;
      int e0;
      fmt = f; pol = p; pha = h; half_div = DW'(d); tx_word = tx;
      exp_pol = (f == 2'b00) ? p : 1'b0;
      exp_pha = (f == 2'b00) ? h : 1'b0;
      exp_h   = (d == 0) ? 1 : d;
      exp_tx  = tx; exp_rx = sw;
      n0 = nfr; e0 = errors;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      if (kind == 1) begin
         tx_word = ~tx;
         repeat (10) @(negedge clk);
         chk(ready == 1'b0, "R9 ready low while busy", ready, 0);
      end
      start = 1'b0;
      if (kind == 2) begin
         repeat (4) @(negedge clk);
         pol = ~p; pha = ~h; half_div = DW'(3);
      end
      while (nfr == n0) @(negedge clk);
      @(negedge clk);
      if (f != 2'b00) chk(errors == e0, "R2 options ignored", errors - e0, 0);
      if (d == 0)     chk(errors == e0, "R11 zero divisor as one", errors - e0, 0);
      if (kind == 2)  chk(errors == e0, "R11 options held for frame", errors - e0, 0);
      if (kind == 1) begin
         bit stayed = 1'b1;
         repeat (6) begin
            @(negedge clk);
            if (!frm_n || !ready) stayed = 1'b0;
         end
         chk(stayed && nfr == n0 + 1, "R9 no extra frame", nfr - n0, 1);
      end
   endtask

   initial begin
      #(CLK_PER * 200000);
      errors++;
      $display("FAIL R5 watchdog act=timeout exp=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(frm_n == 1'b1, "R1 reset frame idle", frm_n, 1);
      chk(ready == 1'b1, "R1 reset ready", ready, 1);
      chk(done == 1'b0,  "R10 reset no done", done, 0);
      chk(sclk == 1'b0,  "R1 reset clock idle", sclk, 0);
      pol = 1'b1;
      @(negedge clk);
      chk(sclk == 1'b1, "R1 idle high with polarity 1", sclk, 1);
      fmt = 2'b10;
      @(negedge clk);
      chk(sclk == 1'b0, "R2 idle low outside SPI format", sclk, 0);

      for (int m = 0; m < 4; m++) begin
         for (int d = 0; d < 4; d++) begin
            for (int w = 0; w < 2; w++) begin
               int idx = m*8 + d*2 + w;
               run_frame(2'b00, m[1], m[0], d, N'(8'hA5 ^ (idx*37)), N'(8'h3C + idx*53), 0);
            end
         end
      end
      for (int f = 1; f < 4; f++) begin
         run_frame(f[1:0], 1'b1, 1'b1, f, N'(8'h81 + f*17), N'(8'h7E - f*9), 0);
      end
      run_frame(2'b00, 1'b0, 1'b1, 2, 8'hC3, 8'h5A, 1);
      run_frame(2'b00, 1'b0, 1'b1, 2, 8'h96, 8'h0F, 2);
      run_frame(2'b00, 1'b1, 1'b0, 1, 8'hFF, 8'h00, 0);
      run_frame(2'b00, 1'b0, 1'b0, 1, 8'h00, 8'hFF, 0);

      chk(idle_bad == 0, "R1 idle clock level", idle_bad, 0);
      chk(done_bad == 0, "R10 stray done", done_bad, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule